// File: doc/BRIEF.md
# Bus Ready Merge and Timeout

This block produces the ready input of an emulated 16-bit processor bus. Two ready sources feed it: one from the emulator's own memory and one from the target system. A single enable bit selects how they combine. When the bit is set, both sources must agree. When it is clear, the source follows the access: local-memory accesses take the local ready, and user-memory accesses take the target's ready. Port (I/O) accesses always count as target-system accesses.

A watchdog measures how long each bus cycle waits for ready. It counts a 1 MHz tick input against a programmed limit in microseconds. On expiry it sets a sticky timeout flag. In the error action it also raises a halt request; in the report-only action it does not. An infinite setting switches the normal timeout off. In that setting a host-initiated transfer still reports a completion timeout after a long fixed limit, which defaults to 15 seconds. The host clears all flags with a single pulse.

Top module: `rdy_merge_wdog`

## Requirements
- R1: While the ready-enable bit is 1, `cpu_rdy` equals `local_rdy AND user_rdy`, whatever the mapping or cycle type.
- R2: While the ready-enable bit is 0 and `io_cycle` is 0, `cpu_rdy` follows `local_rdy` when `map_local` is 1 and follows `user_rdy` when `map_local` is 0.
- R3: While the ready-enable bit is 0 and `io_cycle` is 1, `cpu_rdy` follows `user_rdy` and ignores `local_rdy` and `map_local`.
- R4: After reset the ready-enable bit is 1, the limit is 1000 µs, the action is error (halt), the setting is finite, and all three flags are 0.
- R5: The wait count clears on `cyc_start`. It advances by one on each `tick_1us` clock while the cycle waits with `cpu_rdy` low, and stops once `cpu_rdy` is seen high or `cyc_end` arrives. The timeout fires on the clock edge of the limit-th counted tick.
- R6: With the infinite setting, `tmo_flag` never rises, however long a cycle waits.
- R7: On expiry `tmo_flag` is set. `halt_req` is set as well only if `cfg_halt_on_err` was 1 at the last configuration write.
- R8: A configuration write with `cfg_limit` equal to 0 or of 32768 and above leaves the previous limit in force. The mode bits of that write still load.
- R9: `tmo_flag`, `halt_req` and `host_tmo` stay set until a `sts_clr` pulse clears them.
- R10: With the infinite setting, a cycle started with `host_xfer` = 1 sets `host_tmo` on the edge of tick number HOST_LIMIT_US (default 15,000,000) without ready. `tmo_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| cyc_start | input | 1 | Pulse at the start of a bus cycle |
| cyc_end | input | 1 | Pulse at the end of a bus cycle |
| io_cycle | input | 1 | 1 for a port access, 0 for memory |
| map_local | input | 1 | 1 when the access is mapped to local memory |
| host_xfer | input | 1 | 1 when the cycle is a host transfer (sampled at start) |
| local_rdy | input | 1 | Ready from local memory |
| user_rdy | input | 1 | Ready from the target system |
| cfg_wr | input | 1 | Load the timeout configuration |
| cfg_limit | input | 16 | Timeout limit in microseconds |
| cfg_infinite | input | 1 | 1 selects the infinite setting |
| cfg_halt_on_err | input | 1 | 1 selects error action with halt |
| ena_wr | input | 1 | Load the ready-enable bit |
| ena_val | input | 1 | New ready-enable value |
| sts_clr | input | 1 | Clear all flags |
| cpu_rdy | output | 1 | Ready to the processor |
| tmo_flag | output | 1 | Sticky timeout flag |
| halt_req | output | 1 | Sticky halt request |
| host_tmo | output | 1 | Sticky host completion timeout |

## Verification
A wrong ready-enable bit or a wrong mapping path shows at once on `cpu_rdy`, in the same cycle that the ready inputs change. A count that fails to clear, stop or advance shows up as `tmo_flag` rising one tick early, one tick late or not at all. The bench brackets each limit with a check one tick before expiry and one on it. A limit register that takes a rejected value shows up as a missing or shifted timeout on the next cycle.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  // Width of the programmable microsecond limit (1 .. 2**LIM_W-1)
  localparam int LIM_W = 15;

  typedef struct packed {
    logic [LIM_W-1:0] lim;
    logic             inf;
    logic             halt_en;
  } wd_cfg_t;
endpackage

// File: rtl/rdy_cfg.sv
module rdy_cfg
  import rdy_pkg::*;
#(
  parameter int RST_LIMIT_US = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [LIM_W:0] cfg_limit,
  input  logic           cfg_infinite,
  input  logic           cfg_halt_on_err,
  input  logic           ena_wr,
  input  logic           ena_val,
  output wd_cfg_t        cfg_q,
  output logic           ena_q
);
  wd_cfg_t cfg_d;
  logic    ena_d;
  logic    lim_ok;

  // Value must be non-zero and fit in LIM_W bits
  assign lim_ok = (cfg_limit != '0) && !cfg_limit[LIM_W];

  always_comb begin
    cfg_d = cfg_q;
    ena_d = ena_q;
    if (cfg_wr) begin
      cfg_d.inf     = cfg_infinite;
      cfg_d.halt_en = cfg_halt_on_err;
      if (!cfg_infinite && lim_ok) begin
        cfg_d.lim = cfg_limit[LIM_W-1:0];
      end
    end
    if (ena_wr) begin
      ena_d = ena_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.lim     <= LIM_W'(RST_LIMIT_US);
      cfg_q.inf     <= 1'b0;
      cfg_q.halt_en <= 1'b1;
      ena_q         <= 1'b1;
    end else begin
      cfg_q <= cfg_d;
      ena_q <= ena_d;
    end
  end
endmodule

// File: rtl/rdy_select.sv
module rdy_select (
  input  logic ena,
  input  logic io_cycle,
  input  logic map_local,
  input  logic local_rdy,
  input  logic user_rdy,
  output logic cpu_rdy
);
  logic user_side;

  // Ports live in the target system, so they always use its ready
  assign user_side = io_cycle || !map_local;

  always_comb begin
    if (ena) begin
      cpu_rdy = local_rdy && user_rdy;
    end else if (user_side) begin
      cpu_rdy = user_rdy;
    end else begin
      cpu_rdy = local_rdy;
    end
  end
endmodule

// File: rtl/rdy_wdog.sv
module rdy_wdog
  import rdy_pkg::*;
#(
  parameter int HOST_LIMIT_US = 15_000_000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_1us,
  input  logic    cyc_start,
  input  logic    cyc_end,
  input  logic    host_xfer,
  input  logic    cpu_rdy,
  input  logic    sts_clr,
  input  wd_cfg_t cfg,
  output logic    tmo_flag,
  output logic    halt_req,
  output logic    host_tmo
);
  localparam int HOST_W = $clog2(HOST_LIMIT_US + 1);
  localparam int CNT_W  = ((HOST_W > LIM_W) ? HOST_W : LIM_W) + 1;

  logic             wait_q, wait_d;
  logic             host_q, host_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             tmo_q, tmo_d;
  logic             halt_q, halt_d;
  logic             htmo_q, htmo_d;
  logic             adv, lim_hit, host_hit;

  always_comb begin
    cnt_inc  = cnt_q + CNT_W'(1);
    adv      = wait_q && !cpu_rdy && tick_1us && !cyc_start && (cnt_q != '1);
    lim_hit  = adv && !cfg.inf && (cnt_inc == CNT_W'(cfg.lim));
    host_hit = adv && cfg.inf && host_q && (cnt_inc == CNT_W'(HOST_LIMIT_US));

    wait_d = cyc_start || (wait_q && !cyc_end && !cpu_rdy);
    host_d = cyc_start ? host_xfer : host_q;
    if (cyc_start) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_inc;
    end else begin
      cnt_d = cnt_q;
    end

    tmo_d  = (tmo_q && !sts_clr) || lim_hit;
    halt_d = (halt_q && !sts_clr) || (lim_hit && cfg.halt_en);
    htmo_d = (htmo_q && !sts_clr) || host_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      host_q <= 1'b0;
      cnt_q  <= '0;
      tmo_q  <= 1'b0;
      halt_q <= 1'b0;
      htmo_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      host_q <= host_d;
      cnt_q  <= cnt_d;
      tmo_q  <= tmo_d;
      halt_q <= halt_d;
      htmo_q <= htmo_d;
    end
  end

  assign tmo_flag = tmo_q;
  assign halt_req = halt_q;
  assign host_tmo = htmo_q;
endmodule

// File: rtl/rdy_merge_wdog.sv
module rdy_merge_wdog
  import rdy_pkg::*;
#(
  parameter int RST_LIMIT_US  = 1000,
  parameter int HOST_LIMIT_US = 15_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_1us,
  input  logic           cyc_start,
  input  logic           cyc_end,
  input  logic           io_cycle,
  input  logic           map_local,
  input  logic           host_xfer,
  input  logic           local_rdy,
  input  logic           user_rdy,
  input  logic           cfg_wr,
  input  logic [LIM_W:0] cfg_limit,
  input  logic           cfg_infinite,
  input  logic           cfg_halt_on_err,
  input  logic           ena_wr,
  input  logic           ena_val,
  input  logic           sts_clr,
  output logic           cpu_rdy,
  output logic           tmo_flag,
  output logic           halt_req,
  output logic           host_tmo
);
  wd_cfg_t          cfg_q;
  logic             ena_q;
  logic             inf_q;
  logic [LIM_W-1:0] lim_q;

  assign inf_q = cfg_q.inf;
  assign lim_q = cfg_q.lim;

  rdy_cfg #(.RST_LIMIT_US(RST_LIMIT_US)) u_cfg (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_limit       (cfg_limit),
    .cfg_infinite    (cfg_infinite),
    .cfg_halt_on_err (cfg_halt_on_err),
    .ena_wr          (ena_wr),
    .ena_val         (ena_val),
    .cfg_q           (cfg_q),
    .ena_q           (ena_q)
  );

  rdy_select u_sel (
    .ena       (ena_q),
    .io_cycle  (io_cycle),
    .map_local (map_local),
    .local_rdy (local_rdy),
    .user_rdy  (user_rdy),
    .cpu_rdy   (cpu_rdy)
  );

  rdy_wdog #(.HOST_LIMIT_US(HOST_LIMIT_US)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1us  (tick_1us),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end),
    .host_xfer (host_xfer),
    .cpu_rdy   (cpu_rdy),
    .sts_clr   (sts_clr),
    .cfg       (cfg_q),
    .tmo_flag  (tmo_flag),
    .halt_req  (halt_req),
    .host_tmo  (host_tmo)
  );
endmodule

// File: rtl/rdy_merge_wdog_chk.sv
module rdy_merge_wdog_chk
  import rdy_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             io_cycle,
  input logic             local_rdy,
  input logic             user_rdy,
  input logic             sts_clr,
  input logic             cpu_rdy,
  input logic             tmo_flag,
  input logic             halt_req,
  input logic             host_tmo,
  input logic             ena_q,
  input logic             inf_q,
  input logic [LIM_W-1:0] lim_q
);
  a_r1_and_merge: assert property (@(posedge clk) disable iff (!rst_n)
    ena_q |-> (cpu_rdy == (local_rdy && user_rdy)));

  a_r3_io_user_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_q && io_cycle) |-> (cpu_rdy == user_rdy));

  a_r6_inf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_q && $past(inf_q)) |-> !$rose(tmo_flag));

  a_r7_halt_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> tmo_flag);

  a_r8_limit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q != '0);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !sts_clr) |=> tmo_flag);

  a_r9_host_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tmo && !sts_clr) |=> host_tmo);
endmodule

bind rdy_merge_wdog rdy_merge_wdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_cycle  (io_cycle),
  .local_rdy (local_rdy),
  .user_rdy  (user_rdy),
  .sts_clr   (sts_clr),
  .cpu_rdy   (cpu_rdy),
  .tmo_flag  (tmo_flag),
  .halt_req  (halt_req),
  .host_tmo  (host_tmo),
  .ena_q     (ena_q),
  .inf_q     (inf_q),
  .lim_q     (lim_q)
);

// File: tb/rdy_merge_wdog_bench.sv
module rdy_merge_wdog_bench;
  localparam int HOST_LIM = 40;

  logic clk, rst_n;
  logic tick_1us, cyc_start, cyc_end, io_cycle, map_local, host_xfer;
  logic local_rdy, user_rdy, cfg_wr, cfg_infinite, cfg_halt_on_err;
  logic ena_wr, ena_val, sts_clr;
  logic [15:0] cfg_limit;
  logic cpu_rdy, tmo_flag, halt_req, host_tmo;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  rdy_merge_wdog #(.HOST_LIMIT_US(HOST_LIM)) u_rdy_merge_wdog (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .cyc_start(cyc_start),
    .cyc_end(cyc_end), .io_cycle(io_cycle), .map_local(map_local),
    .host_xfer(host_xfer), .local_rdy(local_rdy), .user_rdy(user_rdy),
    .cfg_wr(cfg_wr), .cfg_limit(cfg_limit), .cfg_infinite(cfg_infinite),
    .cfg_halt_on_err(cfg_halt_on_err), .ena_wr(ena_wr), .ena_val(ena_val),
    .sts_clr(sts_clr), .cpu_rdy(cpu_rdy), .tmo_flag(tmo_flag),
    .halt_req(halt_req), .host_tmo(host_tmo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_1us = 1'b1;
    repeat (n) @(negedge clk);
    tick_1us = 1'b0;
  endtask

  task automatic start_cycle(input logic io, input logic loc, input logic host);
    @(negedge clk);
    io_cycle = io; map_local = loc; host_xfer = host;
    local_rdy = 1'b0; user_rdy = 1'b0;
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  task automatic cfg_write(input logic [15:0] lim, input logic inf, input logic halt);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_limit = lim; cfg_infinite = inf; cfg_halt_on_err = halt;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_ena(input logic v);
    @(negedge clk);
    ena_wr = 1'b1; ena_val = v;
    @(negedge clk);
    ena_wr = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
  endtask

  task automatic drive_rdy(input logic l, input logic u, input logic io, input logic m);
    local_rdy = l; user_rdy = u; io_cycle = io; map_local = m;
    #1;
  endtask

  // R4 reset state and default limit of 1000 with error action
  task automatic t_reset_default();
    chk("R4 tmo_flag after reset", tmo_flag, 1'b0);
    chk("R4 halt_req after reset", halt_req, 1'b0);
    chk("R4 host_tmo after reset", host_tmo, 1'b0);
    drive_rdy(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 enable set after reset (AND)", cpu_rdy, 1'b0);
    start_cycle(1'b0, 1'b1, 1'b0);
    ticks(999);
    chk("R4 no timeout at 999", tmo_flag, 1'b0);
    ticks(1);
    chk("R4 timeout at 1000", tmo_flag, 1'b1);
    chk("R7 default error action halts", halt_req, 1'b1);
    end_cycle();
    clear_flags();
    chk("R9 clear drops flag", tmo_flag, 1'b0);
    chk("R9 clear drops halt", halt_req, 1'b0);
  endtask

  // R1 AND merge with enable set
  task automatic t_and_merge();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drive_rdy(i[0], i[1], 1'b0, i[2]);
      chk("R1 and merge", cpu_rdy, i[0] & i[1]);
    end
  endtask

  // R2 and R3 mapping select with enable clear
  task automatic t_mapped();
    set_ena(1'b0);
    drive_rdy(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 local map follows local_rdy", cpu_rdy, 1'b1);
    drive_rdy(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R2 local map ignores user_rdy", cpu_rdy, 1'b0);
    drive_rdy(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 user map ignores local_rdy", cpu_rdy, 1'b0);
    drive_rdy(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 user map follows user_rdy", cpu_rdy, 1'b1);
    drive_rdy(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 io ignores local_rdy", cpu_rdy, 1'b0);
    drive_rdy(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R3 io follows user_rdy", cpu_rdy, 1'b1);
    set_ena(1'b1);
    drive_rdy(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R1 enable back on", cpu_rdy, 1'b0);
  endtask

  // R8 rejected limits keep the previous one
  task automatic t_reject();
    cfg_write(16'd5, 1'b0, 1'b1);
    cfg_write(16'd0, 1'b0, 1'b1);
    cfg_write(16'd32768, 1'b0, 1'b1);
    start_cycle(1'b0, 1'b1, 1'b0);
    ticks(4);
    chk("R8 limit 5 kept, none at 4", tmo_flag, 1'b0);
    ticks(1);
    chk("R8 limit 5 kept, fires at 5", tmo_flag, 1'b1);
    end_cycle();
    clear_flags();
  endtask

  // R5 count stops on ready and clears on start
  task automatic t_count();
    start_cycle(1'b0, 1'b1, 1'b0);
    ticks(3);
    @(negedge clk);
    local_rdy = 1'b1; user_rdy = 1'b1;
    @(negedge clk);
    local_rdy = 1'b0; user_rdy = 1'b0;
    ticks(10);
    chk("R5 count stops once ready seen", tmo_flag, 1'b0);
    start_cycle(1'b0, 1'b1, 1'b0);
    ticks(4);
    start_cycle(1'b0, 1'b1, 1'b0);
    ticks(4);
    chk("R5 restart clears count", tmo_flag, 1'b0);
    ticks(1);
    chk("R5 fires on fifth tick of new cycle", tmo_flag, 1'b1);
    end_cycle();
    clear_flags();
  endtask

  // R7 report-only action, R9 stickiness
  task automatic t_noerror();
    cfg_write(16'd5, 1'b0, 1'b0);
    start_cycle(1'b0, 1'b0, 1'b0);
    ticks(5);
    chk("R7 report-only sets flag", tmo_flag, 1'b1);
    chk("R7 report-only no halt", halt_req, 1'b0);
    end_cycle();
    repeat (5) @(negedge clk);
    chk("R9 flag holds without clear", tmo_flag, 1'b1);
    clear_flags();
    chk("R9 flag cleared", tmo_flag, 1'b0);
  endtask

  // R6 infinite setting and R10 host completion timeout
  task automatic t_infinite();
    cfg_write(16'd5, 1'b1, 1'b1);
    start_cycle(1'b1, 1'b0, 1'b0);
    ticks(100);
    chk("R6 infinite never times out", tmo_flag, 1'b0);
    chk("R10 no host timeout for plain cycle", host_tmo, 1'b0);
    start_cycle(1'b1, 1'b0, 1'b1);
    ticks(HOST_LIM - 1);
    chk("R10 host timeout not yet", host_tmo, 1'b0);
    ticks(1);
    chk("R10 host timeout at limit", host_tmo, 1'b1);
    chk("R10 tmo_flag stays low", tmo_flag, 1'b0);
    end_cycle();
    repeat (3) @(negedge clk);
    chk("R9 host flag holds", host_tmo, 1'b1);
    clear_flags();
    chk("R9 host flag cleared", host_tmo, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    tick_1us = 0; cyc_start = 0; cyc_end = 0; io_cycle = 0; map_local = 1;
    host_xfer = 0; local_rdy = 0; user_rdy = 0; cfg_wr = 0; cfg_limit = '0;
    cfg_infinite = 0; cfg_halt_on_err = 0; ena_wr = 0; ena_val = 0; sts_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_and_merge();
    t_mapped();
    t_reject();
    t_count();
    t_noerror();
    t_infinite();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule